// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block receives frames on a two-wire synchronous serial link as the slave. The remote master drives a serial clock of about 12 MHz and one data line. The block never drives the serial clock. A much faster system clock samples both wires through register stages. It finds the serial clock's falling edges by comparing consecutive samples and takes one data bit at each falling edge. Nothing in the block is clocked by the serial clock, and a synchronous reset on the system clock always returns it to idle.

A frame opens with one low start bit. Whole bytes follow, most significant bit first: between 10 and 32 bytes, of which the last four carry a CRC-32 over the bytes before them. One high stop bit ends the frame. The end of a frame is recognised when the serial clock stays quiet for a fixed number of system cycles. Every completed byte appears on a byte output with a valid strobe, and the final byte also carries a last strobe. In the cycle of that last strobe, a one-cycle done pulse reports three things: whether the CRC matched, whether the bit count was wrong, and whether the stop bit was low.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_last`, `frame_done`, `frame_crc_ok`, `frame_len_err` and `frame_stop_err` are all 0, and the receiver waits for a start bit.
- R2: Each falling edge of `sclk_in` (seen after the input registers) takes exactly one bit from `sdat_in`. Bits form bytes most significant bit first, and every completed byte of a frame appears once on `rx_byte` with `rx_valid` high, in arrival order.
- R3: While idle, a frame starts at a falling edge where `sdat_in` is 0. Falling edges where `sdat_in` is 1 are ignored: they produce no byte and no `frame_done`.
- R4: A frame ends once no falling edge of `sclk_in` has been seen for IDLE_LIMIT (default 64) system cycles. A gap of 40 system cycles inside a frame does not end it.
- R5: The final completed byte of a frame carries `rx_last` = 1, in the same cycle as `frame_done`. No other byte carries `rx_last`.
- R6: `frame_done` is a single-cycle pulse, given exactly once per frame.
- R7: `frame_len_err` is 1 at `frame_done` unless the bits after the start bit number exactly 8·n+1 with n from 10 to 32.
- R8: `frame_stop_err` is 1 at `frame_done` when exactly one bit follows the last whole byte and that bit is 0.
- R9: `frame_crc_ok` is 1 at `frame_done` exactly when `frame_len_err` is 0 and the reflected CRC-32 of all bytes but the last four equals the 32-bit value made of those four bytes, with the first of them least significant. The CRC uses polynomial 0x04C11DB7, start value 0xFFFFFFFF and final inversion 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the master, idles high |
| sdat_in | input | 1 | Serial data from the master, idles high |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_byte` holds a new byte this cycle |
| rx_last | output | 1 | This byte is the last of its frame |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| frame_crc_ok | output | 1 | CRC matched (valid with `frame_done`) |
| frame_len_err | output | 1 | Bit count or byte count out of rule (valid with `frame_done`) |
| frame_stop_err | output | 1 | Stop bit was low (valid with `frame_done`) |

## Verification
Two things happen in the same cycle: the last byte is released from its holdback register and the frame status is reported. Both are triggered by the quiet-time counter expiring. The bench collects every strobe at the falling system edge and requires the last-flagged byte and the done pulse in one cycle, with the status matching the expected values for that frame. Random frames mix good and corrupted CRCs. Directed frames cover the byte-count limits, a low stop bit, a missing or extra tail bit, a mid-frame pause shorter than the quiet limit, and idle clocking with the data line high.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    // register value left after running data followed by its own CRC
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

    typedef enum logic {
        ST_IDLE,
        ST_RECV
    } rx_state_e;

    typedef struct packed {
        logic fall;   // serial clock falling edge seen this cycle
        logic bit_v;  // data value aligned with that edge
    } edge_ev_t;

    typedef struct packed {
        logic crc_ok;
        logic len_err;
        logic stop_err;
    } frame_status_t;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RESET_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rx_edge.sv
module rx_edge
    import sfr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     sdat_s,
    output edge_ev_t ev
);
    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b1;
        else     sclk_prev <= sclk_s;
    end

    assign ev.fall  = sclk_prev & ~sclk_s;
    assign ev.bit_v = sdat_s;

    // R2: one edge yields one bit, never two cycles in a row
    p_fall_single_r2: assert property (@(posedge clk) disable iff (rst)
        ev.fall |=> !ev.fall);
endmodule

// File: rtl/rx_crc.sv
module rx_crc
    import sfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init,
    input  logic       en,
    input  logic [7:0] data,
    output logic       match
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= CRC_SEED;
        else if (en)     crc_q <= crc32_byte(crc_q, data);
    end

    assign match = (crc_q == CRC_RESIDUE);

    // R9: a new frame always starts from the seed
    p_seed_r9: assert property (@(posedge clk) disable iff (rst)
        init |=> !match);
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import sfr_pkg::*;
#(
    parameter int MIN_BYTES  = 10,
    parameter int MAX_BYTES  = 32,
    parameter int IDLE_LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_ev_t      ev,
    input  logic          crc_match,
    output logic          crc_init,
    output logic          crc_en,
    output logic [7:0]    crc_data,
    output logic [7:0]    out_byte,
    output logic          out_valid,
    output logic          out_last,
    output logic          done,
    output frame_status_t status
);
    localparam int NBW = $clog2(MAX_BYTES + 2);
    localparam int GW  = $clog2(IDLE_LIMIT + 1);
    localparam logic [NBW-1:0] NB_MIN = NBW'(MIN_BYTES);
    localparam logic [NBW-1:0] NB_MAX = NBW'(MAX_BYTES);
    localparam logic [NBW-1:0] NB_SAT = NBW'(MAX_BYTES + 1);
    localparam logic [GW-1:0]  GAP_END = GW'(IDLE_LIMIT - 1);

    rx_state_e      state;
    logic [7:0]     shreg;
    logic [2:0]     nib;
    logic [NBW-1:0] nbytes;
    logic [GW-1:0]  gap;
    logic [7:0]     pend;
    logic           pend_v;
    logic           last_bit;
    logic [7:0]     next_byte;

    assign next_byte = {shreg[6:0], ev.bit_v};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            nib       <= '0;
            nbytes    <= '0;
            gap       <= '0;
            pend      <= '0;
            pend_v    <= 1'b0;
            last_bit  <= 1'b0;
            crc_init  <= 1'b0;
            crc_en    <= 1'b0;
            crc_data  <= '0;
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            done      <= 1'b0;
            status    <= '0;
        end else begin
            crc_init  <= 1'b0;
            crc_en    <= 1'b0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            done      <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ev.fall && !ev.bit_v) begin
                        state    <= ST_RECV;
                        nib      <= '0;
                        nbytes   <= '0;
                        gap      <= '0;
                        pend_v   <= 1'b0;
                        crc_init <= 1'b1;
                    end
                end
                ST_RECV: begin
                    if (ev.fall) begin
                        gap      <= '0;
                        shreg    <= next_byte;
                        last_bit <= ev.bit_v;
                        if (nib == 3'd7) begin
                            nib      <= '0;
                            crc_en   <= 1'b1;
                            crc_data <= next_byte;
                            pend     <= next_byte;
                            pend_v   <= 1'b1;
                            if (nbytes != NB_SAT) nbytes <= nbytes + 1'b1;
                            if (pend_v) begin
                                out_byte  <= pend;
                                out_valid <= 1'b1;
                            end
                        end else begin
                            nib <= nib + 3'd1;
                        end
                    end else if (gap == GAP_END) begin
                        state           <= ST_IDLE;
                        done            <= 1'b1;
                        status.len_err  <= (nib != 3'd1) || (nbytes < NB_MIN) || (nbytes > NB_MAX);
                        status.stop_err <= (nib == 3'd1) && !last_bit;
                        status.crc_ok   <= (nib == 3'd1) && (nbytes >= NB_MIN) &&
                                           (nbytes <= NB_MAX) && crc_match;
                        if (pend_v) begin
                            out_byte  <= pend;
                            out_valid <= 1'b1;
                            out_last  <= 1'b1;
                        end
                        pend_v <= 1'b0;
                    end else begin
                        gap <= gap + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: last strobe only together with the end-of-frame pulse
    p_last_with_done_r5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (done && out_valid));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: the end is only declared after a cycle without a serial edge
    p_quiet_end_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!ev.fall));

    // R3: an idle receiver emits nothing
    p_idle_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !done) |-> !out_valid);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_BYTES   = 10,
    parameter int MAX_BYTES   = 32,
    parameter int IDLE_LIMIT  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_in,
    input  logic       sdat_in,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_last,
    output logic       frame_done,
    output logic       frame_crc_ok,
    output logic       frame_len_err,
    output logic       frame_stop_err
);
    localparam int LANES = 2;

    logic [LANES-1:0] lanes_raw;
    logic [LANES-1:0] lanes_s;
    edge_ev_t         ev;
    logic             crc_init;
    logic             crc_en;
    logic [7:0]       crc_data;
    logic             crc_match;
    frame_status_t    status;

    assign lanes_raw = {sclk_in, sdat_in};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rx_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b1)
        ) u_sync (
            .clk(clk),
            .rst(rst),
            .d  (lanes_raw[l]),
            .q  (lanes_s[l])
        );
    end

    rx_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .sclk_s(lanes_s[1]),
        .sdat_s(lanes_s[0]),
        .ev    (ev)
    );

    rx_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (crc_init),
        .en   (crc_en),
        .data (crc_data),
        .match(crc_match)
    );

    rx_framer #(
        .MIN_BYTES (MIN_BYTES),
        .MAX_BYTES (MAX_BYTES),
        .IDLE_LIMIT(IDLE_LIMIT)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .crc_match(crc_match),
        .crc_init (crc_init),
        .crc_en   (crc_en),
        .crc_data (crc_data),
        .out_byte (rx_byte),
        .out_valid(rx_valid),
        .out_last (rx_last),
        .done     (frame_done),
        .status   (status)
    );

    assign frame_crc_ok   = status.crc_ok;
    assign frame_len_err  = status.len_err;
    assign frame_stop_err = status.stop_err;
endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb_top;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_in = 1'b1;
    logic sdat_in = 1'b1;
    logic [7:0] rx_byte;
    logic rx_valid, rx_last, frame_done, frame_crc_ok, frame_len_err, frame_stop_err;

    always #5 clk = ~clk;

    serial_frame_rx dut_i (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdat_in(sdat_in),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last),
        .frame_done(frame_done), .frame_crc_ok(frame_crc_ok),
        .frame_len_err(frame_len_err), .frame_stop_err(frame_stop_err)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] fb [0:39];
    logic [7:0] cap [0:47];
    logic       cap_last [0:47];
    int ncap = 0;
    int ndone = 0;
    logic st_crc, st_len, st_stop;
    int done_idx = -1;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid && ncap < 48) begin
                cap[ncap] = rx_byte;
                cap_last[ncap] = rx_last;
                ncap++;
            end
            if (frame_done) begin
                ndone++;
                st_crc = frame_crc_ok;
                st_len = frame_len_err;
                st_stop = frame_stop_err;
                done_idx = ncap;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ fb[i][b]) c = (c >> 1) ^ 32'hEDB88320;
                else c = c >> 1;
            end
        end
        return ~c;
    endfunction

    // payload random, CRC appended least significant byte first
    task automatic build(input int nbytes, input bit corrupt);
        logic [31:0] c;
        for (int i = 0; i < nbytes - 4; i++) fb[i] = 8'($urandom);
        c = ref_crc(nbytes - 4);
        for (int k = 0; k < 4; k++) fb[nbytes - 4 + k] = c[8*k +: 8];
        if (corrupt) fb[0] = fb[0] ^ 8'h10;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdat_in = b;
        repeat (HALF) @(negedge clk);
        sclk_in = 1'b0;
        repeat (HALF) @(negedge clk);
        sclk_in = 1'b1;
    endtask

    task automatic send(input int nbytes, input int tail, input logic stopv, input int pause_at);
        send_bit(1'b0);
        for (int i = 0; i < nbytes; i++) begin
            for (int b = 7; b >= 0; b--) send_bit(fb[i][b]);
            if (i == pause_at) repeat (40) @(negedge clk);
        end
        for (int t = 0; t < tail; t++) send_bit(t == 0 ? stopv : 1'b1);
        @(negedge clk);
        sdat_in = 1'b1;
    endtask

    task automatic run_frame(input string tag, input int nbytes, input bit corrupt,
                             input int tail, input logic stopv, input int pause_at);
        bit exp_len, exp_stop, exp_crc, lastok;
        ncap = 0;
        ndone = 0;
        done_idx = -1;
        build(nbytes, corrupt);
        send(nbytes, tail, stopv, pause_at);
        exp_len = (tail != 1) || nbytes < 10 || nbytes > 32;
        exp_stop = (tail == 1) && (stopv == 1'b0);
        exp_crc = !exp_len && !corrupt;
        repeat (40) @(negedge clk);
        check(ndone == 0, {tag, " R4 early end"}, ndone, 0);
        repeat (120) @(negedge clk);
        check(ndone == 1, {tag, " R6 done count"}, ndone, 1);
        check(ncap == nbytes, {tag, " R2 byte count"}, ncap, nbytes);
        for (int i = 0; i < nbytes && i < ncap; i++)
            check(cap[i] == fb[i], {tag, " R2 byte value"}, cap[i], fb[i]);
        lastok = 1;
        for (int i = 0; i < ncap; i++)
            if (cap_last[i] != (i == ncap - 1)) lastok = 0;
        check(lastok, {tag, " R5 last flag"}, lastok, 1);
        check(done_idx == ncap, {tag, " R5 last with done"}, done_idx, ncap);
        check(st_len == exp_len, {tag, " R7 len_err"}, st_len, exp_len);
        check(st_stop == exp_stop, {tag, " R8 stop_err"}, st_stop, exp_stop);
        check(st_crc == exp_crc, {tag, " R9 crc_ok"}, st_crc, exp_crc);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!rx_valid && !rx_last && !frame_done, "R1 strobes idle", {rx_valid, rx_last, frame_done}, 0);
        check(!frame_crc_ok && !frame_len_err && !frame_stop_err, "R1 status idle",
              {frame_crc_ok, frame_len_err, frame_stop_err}, 0);

        // R3: idle clocking with data high is ignored
        ncap = 0; ndone = 0;
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        repeat (150) @(negedge clk);
        check(ncap == 0, "R3 idle edges give no byte", ncap, 0);
        check(ndone == 0, "R3 idle edges give no done", ndone, 0);

        // directed corners
        run_frame("min10", 10, 0, 1, 1'b1, -1);
        run_frame("max32", 32, 0, 1, 1'b1, -1);
        run_frame("over33", 33, 0, 1, 1'b1, -1);
        run_frame("under9", 9, 0, 1, 1'b1, -1);
        run_frame("stoplow", 16, 0, 1, 1'b0, -1);
        run_frame("notail", 12, 0, 0, 1'b1, -1);
        run_frame("tail3", 12, 0, 3, 1'b1, -1);
        run_frame("pause", 14, 0, 1, 1'b1, 3);
        run_frame("badcrc", 20, 1, 1, 1'b1, -1);

        // random frames
        for (int f = 0; f < 16; f++) begin
            run_frame("rand", 10 + int'($urandom % 23), ($urandom % 4) == 0, 1, 1'b1, -1);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule